// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt lines onto sixteen inputs of a legacy interrupt controller. Software programs one byte-wide routing register per PCI line through a simple dword config-write port. A routing value below sixteen names the controller input that the line drives. A value of sixteen or more switches the line off.

Internally the block holds one level bit for every pair of controller input and PCI line. Each controller output is the OR of the bits that belong to it, so two lines that share an input behave as a wired-OR. When a write touches any routing byte, the bit map is rebuilt from the live line levels in the next cycle. This removes stale bits that the previous mapping left behind.

A separate combinational query port maps a device number and INTx pin onto a PCI line by slot rotation. It reports whether that line is routed and to which controller input.

Top module: `pirq_router`

## Requirements
- R1: The four routing bytes form the dword at byte address 0x60 (cfg_addr must equal 0x60 exactly). Byte lane k (cfg_wdata bits [8k+7:8k]) holds the route of PCI line k, with A=0, B=1, C=2, D=3. A lane is written only when cfg_be[k] is set. A write to any other address changes no route.
- R2: After reset every route is 0x80, so all lines are off, and irq_out is all zero.
- R3: A line whose route is 16 or more drives no output, whatever its level. A route of 15 is still a valid target.
- R4: With the routing stable, a level change on an enabled line shows on irq_out[route] after exactly one rising clock edge.
- R5: A controller output stays high while any line routed to it is high, and it falls only when all of them are low.
- R6: After a routing write, irq_out reflects only the new mapping from the second rising edge on (the write edge, then the rebuild edge). Bits left at an old target are cleared.
- R7: The query line is (q_pin + q_dev - 1) mod 4, where q_pin is 0 for INTA through 3 for INTD and q_dev is the 5-bit device number.
- R8: The query reports q_en=1 and q_tgt equal to the route of the query line when that route is below 16. Otherwise it reports q_en=0 and q_tgt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 8 | Config byte address of the dword |
| cfg_be | input | 4 | Byte enables, one per lane |
| cfg_wdata | input | 32 | Config write data |
| line_in | input | 4 | PCI interrupt line levels, A in bit 0 |
| irq_out | output | 16 | Registered legacy controller inputs |
| q_dev | input | 5 | Query device number |
| q_pin | input | 2 | Query INTx pin, 0 is INTA |
| q_line | output | 2 | PCI line the query pin lands on |
| q_en | output | 1 | Query line is routed |
| q_tgt | output | 4 | Controller input of the query line |

## Verification
A wrong level bit appears as a controller output that is high with no routed line high, or low while a routed line is high. The deciding case is a reroute while the line is asserted: the old target must fall and the new one must rise within two edges of the write. A wrong routing byte or lane decode shows at once on the combinational query port, and at the next line change on irq_out. Shared targets are checked by dropping lines one at a time, because a lost OR term shows only when one of several sources falls.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int unsigned PR_LINES     = 4;
    localparam int unsigned PR_TARGETS   = 16;
    localparam int unsigned PR_ROUTE_W   = 8;
    localparam int unsigned PR_ADDR_W    = 8;
    localparam int unsigned PR_DEV_W     = 5;
    localparam logic [7:0]  PR_ROUTE_RST = 8'h80;
    localparam logic [7:0]  PR_ROUTE_ADR = 8'h60;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINES = PR_LINES,
    parameter int unsigned RT_W    = PR_ROUTE_W,
    parameter int unsigned ADDR_W  = PR_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE  = ADDR_W'(PR_ROUTE_ADR),
    parameter logic [RT_W-1:0]   RST_V = RT_W'(PR_ROUTE_RST)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_LINES-1:0]            be,
    input  logic [N_LINES*RT_W-1:0]       wdata,
    output logic [N_LINES-1:0][RT_W-1:0]  route,
    output logic                          rebuild
);
    typedef struct packed {
        logic [N_LINES-1:0][RT_W-1:0] route;
        logic                         rebuild;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic       hit;

    always_comb begin
        state_d         = state_q;
        hit             = we && (addr == BASE) && (|be);
        state_d.rebuild = hit;
        for (int l = 0; l < N_LINES; l++) begin
            if (hit && be[l]) begin
                state_d.route[l] = wdata[l*RT_W +: RT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.route   <= {N_LINES{RST_V}};
            state_q.rebuild <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign route   = state_q.route;
    assign rebuild = state_q.rebuild;

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || addr != BASE) |=> $stable(route)); // R1
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINES = PR_LINES,
    parameter int unsigned N_TGT   = PR_TARGETS,
    parameter int unsigned RT_W    = PR_ROUTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LINES-1:0][RT_W-1:0]  route,
    input  logic                          rebuild,
    input  logic [N_LINES-1:0]            line_in,
    output logic [N_TGT-1:0]              irq_out
);
    localparam int unsigned TGT_W = $clog2(N_TGT);
    localparam int unsigned MAP_W = N_TGT * N_LINES;
    localparam logic [RT_W-1:0] TGT_LIM = RT_W'(N_TGT);

    typedef struct packed {
        logic [MAP_W-1:0] lvl;
        logic [N_TGT-1:0] irq;
    } map_state_t;

    map_state_t          state_d, state_q;
    logic [N_LINES-1:0]  live;

    always_comb begin
        for (int l = 0; l < N_LINES; l++) begin
            live[l] = route[l] < TGT_LIM;
        end
    end

    always_comb begin
        state_d     = state_q;
        if (rebuild) begin
            state_d.lvl = '0;
        end
        for (int l = 0; l < N_LINES; l++) begin
            if (live[l]) begin
                state_d.lvl[int'(route[l][TGT_W-1:0]) * N_LINES + l] = line_in[l];
            end
        end
        for (int t = 0; t < N_TGT; t++) begin
            state_d.irq[t] = |state_d.lvl[t*N_LINES +: N_LINES];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_out = state_q.irq;

    AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rebuild && live == '0) |=> (irq_out == '0)); // R3
    AST_REBUILT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rebuild |=> ($countones(irq_out) <= N_LINES)); // R6

    for (genvar g = 0; g < N_LINES; g++) begin : g_follow
        AST_LEVEL_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
            (live[g] && line_in[g]) |=> irq_out[$past(route[g][TGT_W-1:0])]); // R4
    end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINES = PR_LINES,
    parameter int unsigned N_TGT   = PR_TARGETS,
    parameter int unsigned RT_W    = PR_ROUTE_W,
    parameter int unsigned DEV_W   = PR_DEV_W
) (
    input  logic [N_LINES-1:0][RT_W-1:0]  route,
    input  logic [DEV_W-1:0]              dev,
    input  logic [$clog2(N_LINES)-1:0]    pin,
    output logic [$clog2(N_LINES)-1:0]    line,
    output logic                          en,
    output logic [$clog2(N_TGT)-1:0]      tgt
);
    localparam int unsigned LINE_W = $clog2(N_LINES);
    localparam int unsigned TGT_W  = $clog2(N_TGT);

    logic [RT_W-1:0] sel;

    always_comb begin
        line = LINE_W'((int'(pin) + int'(dev) + N_LINES - 1) % N_LINES);
        sel  = route[line];
        en   = sel < RT_W'(N_TGT);
        tgt  = en ? sel[TGT_W-1:0] : '0;
    end

    always_comb begin
        assert (en || tgt == '0); // R8
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int unsigned N_LINES = PR_LINES,
    parameter int unsigned N_TGT   = PR_TARGETS,
    parameter int unsigned RT_W    = PR_ROUTE_W,
    parameter int unsigned ADDR_W  = PR_ADDR_W,
    parameter int unsigned DEV_W   = PR_DEV_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [N_LINES-1:0]            cfg_be,
    input  logic [N_LINES*RT_W-1:0]       cfg_wdata,
    input  logic [N_LINES-1:0]            line_in,
    output logic [N_TGT-1:0]              irq_out,
    input  logic [DEV_W-1:0]              q_dev,
    input  logic [$clog2(N_LINES)-1:0]    q_pin,
    output logic [$clog2(N_LINES)-1:0]    q_line,
    output logic                          q_en,
    output logic [$clog2(N_TGT)-1:0]      q_tgt
);
    logic [N_LINES-1:0][RT_W-1:0] route;
    logic                         rebuild;

    pirq_cfg_regs #(.N_LINES(N_LINES), .RT_W(RT_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .be(cfg_be),
        .wdata(cfg_wdata), .route(route), .rebuild(rebuild)
    );

    pirq_level_map #(.N_LINES(N_LINES), .N_TGT(N_TGT), .RT_W(RT_W)) u_map (
        .clk(clk), .rst_n(rst_n), .route(route), .rebuild(rebuild),
        .line_in(line_in), .irq_out(irq_out)
    );

    pirq_swizzle #(.N_LINES(N_LINES), .N_TGT(N_TGT), .RT_W(RT_W), .DEV_W(DEV_W)) u_swz (
        .route(route), .dev(q_dev), .pin(q_pin), .line(q_line), .en(q_en), .tgt(q_tgt)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0)); // R2
endmodule

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  line_in = '0;
    logic [15:0] irq_out;
    logic [4:0]  q_dev = '0;
    logic [1:0]  q_pin = '0;
    logic [1:0]  q_line;
    logic        q_en;
    logic [3:0]  q_tgt;

    always #2.5 clk = ~clk;

    pirq_router u_pirq_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .line_in(line_in),
        .irq_out(irq_out), .q_dev(q_dev), .q_pin(q_pin), .q_line(q_line),
        .q_en(q_en), .q_tgt(q_tgt)
    );

    typedef struct {
        int          due;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t      sb[$];
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] ref_rt [4];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (irq_out !== it.exp) begin
                fails++;
                $display("FAIL %s irq_out actual=%h expected=%h", it.tag, irq_out, it.exp);
            end
        end
    end

    function automatic logic [15:0] model_irq();
        logic [15:0] v = '0;
        for (int l = 0; l < 4; l++) begin
            if (ref_rt[l] < 8'd16 && line_in[l]) v[ref_rt[l][3:0]] = 1'b1;
        end
        return v;
    endfunction

    task automatic expect_now(string tag);
        sb.push_back('{due: cyc + 1, exp: model_irq(), tag: tag});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        if (a == 8'h60) begin
            for (int l = 0; l < 4; l++) if (be[l]) ref_rt[l] = d[l*8 +: 8];
        end
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic set_lines(logic [3:0] v);
        line_in = v;
    endtask

    task automatic query(logic [4:0] dev, logic [1:0] pin, string tag);
        logic [1:0] el;
        logic       een;
        logic [3:0] et;
        q_dev = dev; q_pin = pin;
        #1;
        el  = 2'((int'(pin) + int'(dev) + 3) % 4);
        een = ref_rt[el] < 8'd16;
        et  = een ? ref_rt[el][3:0] : 4'd0;
        checks++;
        if (q_line !== el || q_en !== een || q_tgt !== et) begin
            fails++;
            $display("FAIL %s query actual=%0d/%0b/%0d expected=%0d/%0b/%0d",
                     tag, q_line, q_en, q_tgt, el, een, et);
        end
    endtask

    initial begin
        for (int l = 0; l < 4; l++) ref_rt[l] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R2 reset outputs low");
        query(5'd1, 2'd0, "R2 R8 reset route off");
        set_lines(4'hF);
        expect_now("R3 lines high while all off");
        cfg_write(8'h60, 4'hF, {8'h80, 8'h10, 8'h0F, 8'h05});
        expect_now("R1 R3 full dword write, 15 live, 16 off");
        cfg_write(8'h64, 4'hF, 32'h01010101);
        expect_now("R1 other address ignored");
        query(5'd1, 2'd0, "R1 R8 route A kept at 5");
        cfg_write(8'h60, 4'b0010, 32'h03030903);
        expect_now("R1 R6 lane B only, stale 15 cleared");
        query(5'd2, 2'd0, "R1 R8 route B is 9");
        set_lines(4'b1110);
        expect_now("R4 line A falls");
        cfg_write(8'h60, 4'b0001, 32'h00000009);
        expect_now("R6 A joins target 9");
        set_lines(4'b1111);
        expect_now("R5 A and B high on 9");
        set_lines(4'b1101);
        expect_now("R5 B drops, A holds 9");
        set_lines(4'b1100);
        expect_now("R5 both drop on 9");
        cfg_write(8'h60, 4'b0100, 32'h00020000);
        expect_now("R4 C routed to 2 while high");
        set_lines(4'b1000);
        expect_now("R4 C falls");
        set_lines(4'b1100);
        expect_now("R4 C rises");
        cfg_write(8'h60, 4'b0100, 32'h00800000);
        expect_now("R3 R6 C switched off while high");
        set_lines(4'b1101);
        cfg_write(8'h60, 4'b0001, 32'h0000000C);
        expect_now("R6 A moves 9 to 12 while high");
        query(5'd3, 2'd2, "R7 dev 3 pin 2");
        query(5'd0, 2'd0, "R7 R8 dev 0 wraps to D");
        query(5'd31, 2'd3, "R7 dev 31 pin 3");
        query(5'd4, 2'd1, "R7 dev 4 pin 1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule